// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the execution pipeline of a small 32-bit processor core. It runs three sequences that change the core's privilege context: entry for a synchronous exception or trap, entry for an accepted hardware interrupt, and the return from an exception. It owns the program counter, the 16-bit status word and two stack pointers, one for supervisor and one for user. A configuration input decides whether the user stack is separate. When that input is low, one stack pointer serves every mode.

On entry the sequencer first raises the supervisor bit. For an interrupt it also loads the interrupt mask and clears the master bit. The stack select follows the new status word, so the frame always lands on the supervisor stack. The block pushes the return address and a packed frame word, then reads the new program counter from a vector table that starts at an externally supplied base. On return it pops the frame from the active stack and moves that stack past the frame. It restores the status word, and the stack select then follows the restored mode.

Every access goes through one 32-bit memory port. Each access holds its request until an acknowledge arrives.

Top module: `exc_seq`

## Requirements
- R1: After reset, pc equals the RESET_PC parameter, sr equals RESET_SR, sp equals RESET_SSP, busy is low and cause is zero.
- R2: On entry, sr bit 13 (supervisor) is set in the cycle after acceptance. For an interrupt, bits 10:8 are loaded with the interrupt level and bit 12 is cleared. For a software exception, bits 12:8 are left unchanged.
- R3: The user stack pointer is active (sp_user high, sp showing it) exactly when usp_en is high and sr bit 13 is clear. Otherwise the supervisor stack pointer is active. On entry the switch happens before any push, so frames are always written while sr bit 13 is set.
- R4: The frame word has bit 31 = 0 and bit 30 = 1. Bits 29:28 hold the low two bits of the supervisor SP before alignment. Bits 27:24 are zero. Bits 23:16 hold the cause number times 4. Bits 15:0 hold the status word from before entry.
- R5: With A the supervisor SP with its low two bits cleared, the return address is written at A-4 and then the frame word at A-8. The final sp is A-8. Every write is word aligned.
- R6: For a software exception with cause 32 to 47 (the trap range), the saved return address is pc+2. For any other software cause, and for every interrupt, it is pc.
- R7: After entry, pc equals the longword read at vbr + 4*cause, and the cause output shows the cause number.
- R8: While idle with no software request, an interrupt is accepted only when irq_level is strictly greater than sr bits 10:8. The accepted irq_vector becomes the cause.
- R9: Return reads the frame word at the active SP and the new pc at SP+4. The old active stack register becomes (SP OR frame bits 29:28) + 8. Then sr becomes frame bits 15:0 and the stack select follows the new sr.
- R10: busy rises in the cycle after a sequence is accepted and falls in the cycle after its last acknowledge. pc and sp are updated with that last acknowledge and stay stable otherwise while busy. mem_req is never high while busy is low.
- R11: When both are present in the same idle cycle, a software exception wins over a return, and either wins over an interrupt. A pending interrupt is judged again against the updated mask after the sequence ends. Requests that arrive while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usp_en | input | 1 | Enables a separate user stack pointer |
| vbr | input | 32 | Base address of the vector table |
| req_exc | input | 1 | Software exception request, one-cycle pulse |
| exc_cause | input | 6 | Cause number of the software exception |
| req_rte | input | 1 | Return-from-exception request, one-cycle pulse |
| irq_level | input | 3 | Pending interrupt level, 0 means none |
| irq_vector | input | 6 | Cause number used for the pending interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | A sequence is in progress |
| pc | output | 32 | Program counter |
| sr | output | 16 | Status word |
| sp | output | 32 | Active stack pointer |
| sp_user | output | 1 | High when the user stack pointer is active |
| cause | output | 6 | Cause number of the most recent entry |

## Verification
A software exception and an interrupt acceptance can fall in the same idle cycle. The bench provokes this by pulsing req_exc while irq_level already exceeds the mask. It then expects two nested frames: the software frame first, and above it the interrupt frame. The interrupt frame must record the status word left by the software entry and the software handler address as its return address. The final cause and mask must come from the interrupt. Requests pulsed during a running sequence are checked for having no effect on the stack, cause or busy line.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int XLEN       = 32;
    localparam int SR_W       = 16;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IM_LSB  = 8;
    localparam int IM_W       = 3;
    localparam int CAUSE_W    = 6;
    localparam int VEC_W      = CAUSE_W + 2;
    localparam int PAD_W      = XLEN - 4 - SR_W - VEC_W;
    localparam int TRAP_FIRST = 32;
    localparam int TRAP_COUNT = 16;
    localparam int NBANK      = 2;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [SR_W-1:0]    sr_t;
    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [IM_W-1:0]    lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_RET,
        ST_PUSH_FRM,
        ST_VEC,
        ST_POP_FRM,
        ST_POP_PC
    } seq_state_e;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_SW,
        PICK_RTE,
        PICK_IRQ
    } pick_e;

    typedef struct packed {
        logic [1:0]       tag;
        logic [1:0]       align;
        logic [PAD_W-1:0] pad;
        logic [VEC_W-1:0] vec;
        sr_t              osr;
    } frame_t;

    localparam logic [1:0] FRAME_TAG = 2'b01;

    function automatic word_t vec_offset(cause_t c);
        return word_t'(c) << 2;
    endfunction

    function automatic logic is_trap(cause_t c);
        return (int'(c) >= TRAP_FIRST) && (int'(c) < TRAP_FIRST + TRAP_COUNT);
    endfunction

    function automatic logic irq_beats_mask(sr_t s, lvl_t l);
        return l > s[SR_IM_LSB +: IM_W];
    endfunction

    function automatic sr_t entry_sr(sr_t s, logic hw, lvl_t l);
        sr_t r;
        r = s;
        r[SR_S_BIT] = 1'b1;
        if (hw) begin
            r[SR_M_BIT] = 1'b0;
            r[SR_IM_LSB +: IM_W] = l;
        end
        return r;
    endfunction

    function automatic word_t build_frame(sr_t osr, logic [1:0] low, cause_t c);
        frame_t f;
        f.tag   = FRAME_TAG;
        f.align = low;
        f.pad   = '0;
        f.vec   = {c, 2'b00};
        f.osr   = osr;
        return word_t'(f);
    endfunction

endpackage

// File: rtl/exc_seq_regs.sv
module exc_seq_regs
    import exc_seq_pkg::*;
#(
    parameter word_t RESET_PC  = '0,
    parameter sr_t   RESET_SR  = 16'h2700,
    parameter word_t RESET_SSP = '0,
    parameter word_t RESET_USP = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  usp_en,
    input  logic  pc_we,
    input  word_t pc_d,
    input  logic  sr_we,
    input  sr_t   sr_d,
    input  logic  sp_we,
    input  word_t sp_d,
    output word_t pc_q,
    output sr_t   sr_q,
    output word_t sp_act,
    output logic  sel_user
);

    localparam int SEL_W = $clog2(NBANK);

    logic [NBANK-1:0][XLEN-1:0] bank;
    logic [SEL_W-1:0]           sel_idx;

    // Stack select follows the live status word: a write to sr in the same
    // edge as a write to sp lands in the bank selected by the old status.
    assign sel_user = usp_en & ~sr_q[SR_S_BIT];
    assign sel_idx  = SEL_W'(sel_user);
    assign sp_act   = bank[sel_idx];

    function automatic word_t bank_reset(int b);
        return (b == 0) ? RESET_SSP : RESET_USP;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
            sr_q <= RESET_SR;
            for (int b = 0; b < NBANK; b++) begin
                bank[b] <= bank_reset(b);
            end
        end else begin
            if (pc_we) pc_q <= pc_d;
            if (sr_we) sr_q <= sr_d;
            if (sp_we) bank[sel_idx] <= sp_d;
        end
    end

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_exc,
    input  cause_t exc_cause,
    input  logic   req_rte,
    input  lvl_t   irq_level,
    input  cause_t irq_vector,
    input  word_t  vbr,
    input  word_t  pc,
    input  sr_t    sr,
    input  word_t  sp,
    output logic   mem_req,
    output logic   mem_we,
    output word_t  mem_addr,
    output word_t  mem_wdata,
    input  word_t  mem_rdata,
    input  logic   mem_ack,
    output logic   pc_we,
    output word_t  pc_d,
    output logic   sr_we,
    output sr_t    sr_d,
    output logic   sp_we,
    output word_t  sp_d,
    output logic   busy,
    output cause_t cause_q
);

    seq_state_e state;
    pick_e      pick;
    word_t      ret_q;
    sr_t        osr_q;
    sr_t        rsr_q;
    logic [1:0] ralign_q;
    word_t      base;

    assign base = {sp[XLEN-1:2], 2'b00};
    assign busy = (state != ST_IDLE);

    always_comb begin
        pick = PICK_NONE;
        if (state == ST_IDLE) begin
            if (req_exc)                           pick = PICK_SW;
            else if (req_rte)                      pick = PICK_RTE;
            else if (irq_beats_mask(sr, irq_level)) pick = PICK_IRQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cause_q  <= '0;
            ret_q    <= '0;
            osr_q    <= '0;
            rsr_q    <= '0;
            ralign_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    unique case (pick)
                        PICK_SW: begin
                            cause_q <= exc_cause;
                            ret_q   <= is_trap(exc_cause) ? pc + word_t'(2) : pc;
                            osr_q   <= sr;
                            state   <= ST_PUSH_RET;
                        end
                        PICK_IRQ: begin
                            cause_q <= irq_vector;
                            ret_q   <= pc;
                            osr_q   <= sr;
                            state   <= ST_PUSH_RET;
                        end
                        PICK_RTE: state <= ST_POP_FRM;
                        default:  state <= ST_IDLE;
                    endcase
                end
                ST_PUSH_RET: if (mem_ack) state <= ST_PUSH_FRM;
                ST_PUSH_FRM: if (mem_ack) state <= ST_VEC;
                ST_VEC:      if (mem_ack) state <= ST_IDLE;
                ST_POP_FRM: begin
                    if (mem_ack) begin
                        rsr_q    <= mem_rdata[SR_W-1:0];
                        ralign_q <= mem_rdata[29:28];
                        state    <= ST_POP_PC;
                    end
                end
                ST_POP_PC:   if (mem_ack) state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = busy;
        mem_we    = (state == ST_PUSH_RET) || (state == ST_PUSH_FRM);
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_RET: begin
                mem_addr  = base - word_t'(4);
                mem_wdata = ret_q;
            end
            ST_PUSH_FRM: begin
                mem_addr  = base - word_t'(8);
                mem_wdata = build_frame(osr_q, sp[1:0], cause_q);
            end
            ST_VEC:     mem_addr = vbr + vec_offset(cause_q);
            ST_POP_FRM: mem_addr = sp;
            ST_POP_PC:  mem_addr = sp + word_t'(4);
            default: ;
        endcase
    end

    always_comb begin
        sr_we = 1'b0;
        sr_d  = sr;
        pc_we = 1'b0;
        pc_d  = mem_rdata;
        sp_we = 1'b0;
        sp_d  = sp;
        if (pick == PICK_SW || pick == PICK_IRQ) begin
            sr_we = 1'b1;
            sr_d  = entry_sr(sr, pick == PICK_IRQ, irq_level);
        end
        if (state == ST_VEC && mem_ack) begin
            pc_we = 1'b1;
            sp_we = 1'b1;
            sp_d  = base - word_t'(8);
        end
        if (state == ST_POP_PC && mem_ack) begin
            pc_we = 1'b1;
            sp_we = 1'b1;
            sp_d  = (sp | word_t'(ralign_q)) + word_t'(8);
            sr_we = 1'b1;
            sr_d  = rsr_q;
        end
    end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'h0000_0400,
    parameter logic [15:0] RESET_SR  = 16'h2700,
    parameter logic [31:0] RESET_SSP = 32'h0000_03F0,
    parameter logic [31:0] RESET_USP = 32'h0000_0200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        usp_en,
    input  logic [31:0] vbr,
    input  logic        req_exc,
    input  logic [5:0]  exc_cause,
    input  logic        req_rte,
    input  logic [2:0]  irq_level,
    input  logic [5:0]  irq_vector,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        busy,
    output logic [31:0] pc,
    output logic [15:0] sr,
    output logic [31:0] sp,
    output logic        sp_user,
    output logic [5:0]  cause
);

    logic  pc_we, sr_we, sp_we;
    word_t pc_d, sp_d;
    sr_t   sr_d;

    exc_seq_regs #(
        .RESET_PC (RESET_PC),
        .RESET_SR (RESET_SR),
        .RESET_SSP(RESET_SSP),
        .RESET_USP(RESET_USP)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .usp_en  (usp_en),
        .pc_we   (pc_we),
        .pc_d    (pc_d),
        .sr_we   (sr_we),
        .sr_d    (sr_d),
        .sp_we   (sp_we),
        .sp_d    (sp_d),
        .pc_q    (pc),
        .sr_q    (sr),
        .sp_act  (sp),
        .sel_user(sp_user)
    );

    exc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_exc   (req_exc),
        .exc_cause (exc_cause),
        .req_rte   (req_rte),
        .irq_level (irq_level),
        .irq_vector(irq_vector),
        .vbr       (vbr),
        .pc        (pc),
        .sr        (sr),
        .sp        (sp),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .pc_we     (pc_we),
        .pc_d      (pc_d),
        .sr_we     (sr_we),
        .sr_d      (sr_d),
        .sp_we     (sp_we),
        .sp_d      (sp_d),
        .busy      (busy),
        .cause_q   (cause)
    );

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_exc,
    input logic        req_rte,
    input logic [2:0]  irq_level,
    input logic        busy,
    input logic [15:0] sr,
    input logic [31:0] pc,
    input logic [31:0] sp,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack
);

    // R10
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R10
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> ($stable(pc) && $stable(sp)));

    // R3
    push_supervisor_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> sr[13]);

    // R5
    write_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00));

    // R2
    sw_entry_sets_s_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_exc) |=> (busy && sr[13]));

    // R8
    irq_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_exc && !req_rte && (irq_level > sr[10:8])) |=> busy);

    // R8
    irq_hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_exc && !req_rte && (irq_level <= sr[10:8])) |=> !busy);

endmodule

bind exc_seq exc_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_exc  (req_exc),
    .req_rte  (req_rte),
    .irq_level(irq_level),
    .busy     (busy),
    .sr       (sr),
    .pc       (pc),
    .sp       (sp),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb;

    localparam logic [31:0] P_PC  = 32'h0000_0400;
    localparam logic [15:0] P_SR  = 16'h2700;
    localparam logic [31:0] P_SSP = 32'h0000_03F0;
    localparam logic [31:0] P_USP = 32'h0000_0200;
    localparam logic [31:0] P_VBR = 32'h0000_0100;

    typedef struct packed {
        logic        usp;
        logic [15:0] ssr;
        logic [1:0]  aln;
        logic        hw;
        logic [5:0]  cse;
        logic [2:0]  lvl;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 16'h0000, 2'd0, 1'b0, 6'd32, 3'd0},
        '{1'b1, 16'h2000, 2'd2, 1'b0, 6'd5,  3'd0},
        '{1'b1, 16'h0300, 2'd0, 1'b1, 6'd40, 3'd5},
        '{1'b0, 16'h0000, 2'd0, 1'b0, 6'd47, 3'd0},
        '{1'b0, 16'h3100, 2'd1, 1'b1, 6'd30, 3'd7},
        '{1'b1, 16'h1000, 2'd0, 1'b0, 6'd48, 3'd0},
        '{1'b1, 16'h2600, 2'd3, 1'b1, 6'd63, 3'd7},
        '{1'b0, 16'h0200, 2'd0, 1'b1, 6'd2,  3'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        usp_en = 1'b0;
    logic        req_exc = 1'b0;
    logic [5:0]  exc_cause = '0;
    logic        req_rte = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [5:0]  irq_vector = '0;
    logic        mem_req, mem_we, busy, sp_user;
    logic [31:0] mem_addr, mem_wdata, pc, sp;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] sr;
    logic [5:0]  cause;

    logic [31:0] mem [0:255];
    int          lat = 0;
    int          wait_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    logic [31:0] m_pc, m_ssp, m_usp;
    logic [15:0] m_sr;

    always #2.5 clk = ~clk;

    exc_seq #(
        .RESET_PC (P_PC),
        .RESET_SR (P_SR),
        .RESET_SSP(P_SSP),
        .RESET_USP(P_USP)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .usp_en    (usp_en),
        .vbr       (P_VBR),
        .req_exc   (req_exc),
        .exc_cause (exc_cause),
        .req_rte   (req_rte),
        .irq_level (irq_level),
        .irq_vector(irq_vector),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .pc        (pc),
        .sr        (sr),
        .sp        (sp),
        .sp_user   (sp_user),
        .cause     (cause)
    );

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] handler(logic [5:0] c);
        return 32'h8000_0000 | (32'(c) << 8);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_user();
        return usp_en && !m_sr[13];
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Model of one entry from the requirements; returns aligned base A.
    task automatic model_entry(input logic hw, input logic [5:0] c, input logic [2:0] l,
                               output logic [31:0] a, output logic [31:0] ret,
                               output logic [31:0] fw);
        logic [15:0] nsr;
        nsr = m_sr | 16'h2000;
        if (hw) nsr = (nsr & ~16'h1700) | (16'(l) << 8);
        a   = m_ssp & ~32'h3;
        ret = (!hw && c >= 6'd32 && c <= 6'd47) ? m_pc + 32'd2 : m_pc;
        fw  = 32'h4000_0000 | (32'(m_ssp[1:0]) << 28) | (32'(c) << 18) | 32'(m_sr);
        m_sr  = nsr;
        m_ssp = a - 32'd8;
        m_pc  = handler(c);
    endtask

    task automatic check_frame(input logic [31:0] a, input logic [31:0] ret, input logic [31:0] fw);
        chk("R5 return address at A-4 (R6)", mem[(a - 32'd4) >> 2], ret);
        chk("R4 frame word at A-8", mem[(a - 32'd8) >> 2], fw);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " pc"}, pc, m_pc);
        chk({tag, " sr"}, 32'(sr), 32'(m_sr));
        chk({tag, " sp"}, sp, m_user() ? m_usp : m_ssp);
        chk("R3 sp_user", 32'(sp_user), 32'(m_user()));
    endtask

    task automatic do_rte(input logic [15:0] fsr, input logic [1:0] aln, input logic [31:0] npc);
        logic [31:0] s;
        logic        was_user;
        was_user = m_user();
        s = was_user ? m_usp : m_ssp;
        mem[s >> 2]         = 32'h4000_0000 | (32'(aln) << 28) | 32'(fsr);
        mem[(s + 32'd4) >> 2] = npc;
        req_rte = 1'b1;
        @(negedge clk);
        req_rte = 1'b0;
        chk("R10 busy after return accept", 32'(busy), 32'd1);
        wait_idle();
        if (was_user) m_usp = (s | 32'(aln)) + 32'd8;
        else          m_ssp = (s | 32'(aln)) + 32'd8;
        m_sr = fsr;
        m_pc = npc;
        check_state("R9 return");
    endtask

    task automatic do_entry(input logic hw, input logic [5:0] c, input logic [2:0] l);
        logic [31:0] a, ret, fw;
        model_entry(hw, c, l, a, ret, fw);
        if (hw) begin
            irq_level = l;
            irq_vector = c;
        end else begin
            req_exc = 1'b1;
            exc_cause = c;
        end
        @(negedge clk);
        req_exc = 1'b0;
        irq_level = '0;
        chk("R10 busy after entry accept", 32'(busy), 32'd1);
        chk("R2 supervisor set after accept", 32'(sr[13]), 32'd1);
        wait_idle();
        check_frame(a, ret, fw);
        check_state("R2 R7 entry");
        chk("R7 R8 cause", 32'(cause), 32'(c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] a1, r1, f1, a2, r2, f2;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int c = 0; c < 64; c++) mem[(P_VBR >> 2) + c] = handler(6'(c));
        m_pc = P_PC; m_sr = P_SR; m_ssp = P_SSP; m_usp = P_USP;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, P_PC);
        chk("R1 sr", 32'(sr), 32'(P_SR));
        chk("R1 sp", sp, P_SSP);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 cause", 32'(cause), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            lat = i % 3;
            usp_en = TBL[i].usp;
            do_rte(TBL[i].ssr, TBL[i].aln, 32'h0000_2000 + 32'(i) * 32'h10);
            do_entry(TBL[i].hw, TBL[i].cse, TBL[i].lvl);
        end

        // R11 software exception and interrupt in the same cycle
        lat = 1;
        usp_en = 1'b1;
        do_rte(16'h2000, 2'd0, 32'h0000_3000);
        model_entry(1'b0, 6'd9, 3'd0, a1, r1, f1);
        model_entry(1'b1, 6'd50, 3'd2, a2, r2, f2);
        req_exc = 1'b1; exc_cause = 6'd9; irq_level = 3'd2; irq_vector = 6'd50;
        @(negedge clk);
        req_exc = 1'b0;
        while (!(cause == 6'd50 && !busy)) @(negedge clk);
        irq_level = '0;
        check_frame(a1, r1, f1);
        check_frame(a2, r2, f2);
        chk("R11 nested frame above software frame", a2, a1 - 32'd8);
        check_state("R11 after both");
        chk("R11 final cause", 32'(cause), 32'd50);

        // R11 requests while busy are dropped
        model_entry(1'b0, 6'd7, 3'd0, a1, r1, f1);
        req_exc = 1'b1; exc_cause = 6'd7;
        @(negedge clk);
        req_exc = 1'b1; exc_cause = 6'd11; req_rte = 1'b1;
        @(negedge clk);
        req_exc = 1'b0; req_rte = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R11 busy stays low", 32'(busy), 32'd0);
        chk("R11 cause of first request", 32'(cause), 32'd7);
        check_frame(a1, r1, f1);
        check_state("R11 single entry");

        // R8 equal level is held off, higher level accepted
        do_rte(16'h2300, 2'd0, 32'h0000_4000);
        irq_level = 3'd3; irq_vector = 6'd20;
        repeat (6) @(negedge clk);
        chk("R8 equal level ignored busy", 32'(busy), 32'd0);
        chk("R8 equal level ignored pc", pc, 32'h0000_4000);
        irq_level = '0;
        do_entry(1'b1, 6'd20, 3'd4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule